// File: doc/BRIEF.md
# Stimulus-Response Decay Interval Timer

This block runs a stimulus-response measurement on a device under test and times how long the device takes to settle. A start request turns on a free-running square-wave stimulus. The block then waits for the device's single-bit response to rise. After the rise it keeps the stimulus on for a fixed hold period, then switches the stimulus off. It then counts clock cycles until the response falls back low.

The count is reported on a result bus together with a one-cycle completion pulse. If either wait stage runs past its limit, the block gives up, raises a one-cycle timeout pulse and goes back to idle. In that case no completion pulse is produced.

Control is a small state machine with four states: idle, arming, holding and measuring. The response input is asynchronous to the clock, so it passes through a two-flop synchronizer. Rising and falling edges are taken from the synchronized copy. All periods and limits are parameters. The defaults assume a 40 MHz clock, a 1 kHz stimulus and a 10 ms hold.

Top module: `stim_interval_timer`

## Requirements
- R1: While reset is held and on the cycle after it is released, `stim`, `done` and `timeout` are low and `interval` is zero.
- R2: `start` is sampled high in idle at clock edge S. From edge S+k onward, for as long as the train runs, `stim` equals 1 exactly when (k mod PERIOD) is less than HIGH_CYCLES.
- R3: `resp` is first sampled high at edge A while arming. The stimulus follows the R2 pattern until edge A+HOLD_CYCLES+2. From that edge on it stays low. That edge is called the stop edge T.
- R4: `resp` is first sampled low at edge F while measuring. `done` is high for the cycle after edge F+2, and `interval` then holds (F+2)−T, the number of edges from the stop edge up to and including the completion edge.
- R5: `done` lasts exactly one cycle. `interval` keeps its value until the next accepted start, which clears it to zero at edge S.
- R6: No rising response edge may reach the state machine before RISE_TIMEOUT edges after S. In that case `timeout` is high for the one cycle after edge S+RISE_TIMEOUT, `stim` is low from that edge on, and `done` stays low.
- R7: No falling response edge may reach the state machine before FALL_TIMEOUT edges after T. In that case `timeout` is high for the one cycle after edge T+FALL_TIMEOUT, and `done` stays low. `done` and `timeout` are never high together.
- R8: `start` asserted while arming, holding or measuring has no effect: the stimulus pattern, the result and the end-of-run timing are unchanged.
- R9: `stim` is low in idle and while measuring.
- R10: Only a low-to-high transition of the synchronized response ends arming. A response that is already high when start is accepted and stays high leads to the R6 timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a measurement; honoured only in idle |
| resp | input | 1 | Asynchronous response bit from the device under test |
| stim | output | 1 | Stimulus pulse train to the device under test |
| interval | output | CNT_W | Measured decay interval in clock cycles |
| done | output | 1 | One-cycle pulse when a measurement completes |
| timeout | output | 1 | One-cycle pulse when a wait stage runs past its limit |

## Verification
The checker properties assume that reset is applied at the start, so the result register and the pulse flags begin from known values. They also assume `start` is a plain level that can show up in any state. The bench makes that assumption real: it asserts `start` in the middle of the arming and measuring stages, and changes `start` and `resp` only just after a rising edge. Runs with an early response rise and a slow fall are swept near-exhaustively against both timeout limits. With those inputs, every result and every stop edge can be predicted from edge counts alone.

// File: rtl/stim_interval_timer.sv
module stim_interval_timer #(
  parameter int PERIOD       = 40000,
  parameter int HIGH_CYCLES  = 20000,
  parameter int HOLD_CYCLES  = 400000,
  parameter int RISE_TIMEOUT = 40000000,
  parameter int FALL_TIMEOUT = 40000000,
  parameter int CNT_W        = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             resp,
  output logic             stim,
  output logic [CNT_W-1:0] interval,
  output logic             done,
  output logic             timeout
);
  localparam int PH_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(PERIOD - 1);
  localparam logic [PH_W-1:0]  PH_HIGH   = PH_W'(HIGH_CYCLES);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYCLES - 1);
  localparam logic [CNT_W-1:0] RISE_LAST = CNT_W'(RISE_TIMEOUT - 1);
  localparam logic [CNT_W-1:0] FALL_LAST = CNT_W'(FALL_TIMEOUT - 1);

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_HOLD, S_MEAS} state_t;

  state_t           st;
  logic [2:0]       rsync;
  logic [CNT_W-1:0] cnt;
  logic [PH_W-1:0]  ph;

  wire rise    = rsync[1] & ~rsync[2];
  wire fall    = ~rsync[1] & rsync[2];
  wire running = (st == S_ARM) || (st == S_HOLD);

  assign stim = running && (ph < PH_HIGH);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      rsync    <= '0;
      cnt      <= '0;
      ph       <= '0;
      interval <= '0;
      done     <= 1'b0;
      timeout  <= 1'b0;
    end else begin
      rsync   <= {rsync[1:0], resp};
      done    <= 1'b0;
      timeout <= 1'b0;
      cnt     <= cnt + 1'b1;
      ph      <= (ph == PH_LAST) ? '0 : ph + 1'b1;
      case (st)
        S_IDLE: if (start) begin
          st       <= S_ARM;
          cnt      <= '0;
          ph       <= '0;
          interval <= '0;
        end
        S_ARM: if (rise) begin
          st  <= S_HOLD;
          cnt <= '0;
        end else if (cnt == RISE_LAST) begin
          st      <= S_IDLE;
          timeout <= 1'b1;
        end
        S_HOLD: if (cnt == HOLD_LAST) begin
          st  <= S_MEAS;
          cnt <= '0;
        end
        S_MEAS: if (fall) begin
          st       <= S_IDLE;
          interval <= cnt + 1'b1;
          done     <= 1'b1;
        end else if (cnt == FALL_LAST) begin
          st      <= S_IDLE;
          timeout <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stim_interval_timer_chk.sv
module stim_interval_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             stim,
  input logic [CNT_W-1:0] interval,
  input logic             done,
  input logic             timeout
);
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_result_held_r5: assert property (@(posedge clk) disable iff (rst)
    !start |=> (done || $stable(interval)));

  p_end_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    !(done && timeout));

  p_stim_off_at_done_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !stim);

  p_stim_off_after_timeout_r6: assert property (@(posedge clk) disable iff (rst)
    timeout |-> !stim);

  p_timeout_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    timeout |=> !timeout);
endmodule

bind stim_interval_timer stim_interval_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .stim(stim),
  .interval(interval), .done(done), .timeout(timeout)
);

// File: tb/stim_interval_timer_test.sv
module stim_interval_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int P    = 5;
  localparam int H    = 2;
  localparam int HOLD = 6;
  localparam int RTO  = 20;
  localparam int FTO  = 16;
  localparam int CW   = 32;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, resp = 1'b0;
  logic stim, done, timeout;
  logic [CW-1:0] interval;
  int n_checks = 0, n_fail = 0;

  stim_interval_timer #(.PERIOD(P), .HIGH_CYCLES(H), .HOLD_CYCLES(HOLD),
    .RISE_TIMEOUT(RTO), .FALL_TIMEOUT(FTO), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .start(start), .resp(resp),
    .stim(stim), .interval(interval), .done(done), .timeout(timeout));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // w: cycles after the start edge at which resp rises (<0 never)
  // d: cycles after the stop edge at which resp falls (<0 never)
  task automatic trial(input int w, input int d, input bit pre_high, input bit poke);
    int stop_k, done_k, to_k, stim_end, last_k, res;
    bit exp_s;
    resp = pre_high;
    repeat (4) @(posedge clk);
    #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    stop_k   = (w >= 0) ? w + 3 + HOLD : -1;
    done_k   = (w >= 0 && d >= 0) ? stop_k + d + 3 : -1;
    to_k     = (w < 0) ? RTO : ((d < 0) ? stop_k + FTO : -1);
    stim_end = (w >= 0) ? stop_k : RTO;
    last_k   = ((done_k >= 0) ? done_k : to_k) + 2;
    for (int k = 0; k <= last_k; k++) begin
      if (k > 0) begin @(posedge clk); #1; end
      if (w >= 0 && k == w) resp = 1'b1;
      if (d >= 0 && stop_k >= 0 && k == stop_k + d) resp = 1'b0;
      start = poke && (k == 2 || (stop_k >= 0 && k == stop_k + 1));
      @(negedge clk);
      exp_s = (k < stim_end) && ((k % P) < H);
      if (k < stim_end)
        check(stim == exp_s, "R2", "stim pattern", stim, exp_s);
      else if (w >= 0)
        check(stim == 1'b0, "R3", "stim after stop", stim, 0);
      else
        check(stim == 1'b0, "R6", "stim after rise timeout", stim, 0);
      if (poke && k == 4)
        check(stim == exp_s, "R8", "stim after ignored start", stim, exp_s);
      check(done == (k == done_k), "R4", "done timing", done, k == done_k);
      if (w < 0)
        check(timeout == (k == to_k), pre_high ? "R10" : "R6", "rise timeout", timeout, k == to_k);
      else
        check(timeout == (k == to_k), "R7", "fall timeout", timeout, k == to_k);
      res = (done_k >= 0 && k >= done_k) ? d + 3 : 0;
      if (k == 0)
        check(interval == 0, "R5", "cleared on start", interval, 0);
      else
        check(interval == CW'(res), (k > done_k && done_k >= 0) ? "R5" : "R4",
              "interval", interval, res);
    end
    start = 1'b0;
    resp  = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(stim == 0 && done == 0 && timeout == 0 && interval == 0,
          "R1", "outputs in reset", {stim, done, timeout}, 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(stim == 0 && done == 0 && timeout == 0 && interval == 0,
          "R1", "outputs after reset", interval, 0);
    check(stim == 1'b0, "R9", "stim idle", stim, 0);
    for (int w = 0; w <= RTO - 3; w++)
      for (int d = 0; d <= FTO - 3; d++)
        trial(w, d, 1'b0, ((w + d) % 3) == 0);
    trial(-1, -1, 1'b0, 1'b0);
    trial(-1, -1, 1'b1, 1'b0);
    trial(3, -1, 1'b0, 1'b1);
    trial(RTO - 3, FTO - 3, 1'b0, 1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(stim == 1'b0, "R9", "stim idle at end", stim, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule